// File: doc/BRIEF.md
# Voltage comparator control and interrupt logic

This block is the digital side of one analog voltage comparator. A byte-wide control register on a simple CPU register bus sets the comparator's enable, its positive and negative input choices and the pin output enable. The select bits go straight out to the analog multiplexers. The block takes the raw comparator decision, which is asynchronous to the CPU clock, and passes it through a synchronizer to make a readable result bit. It raises a sticky interrupt flag every time that result changes. It can also route the raw decision to an output pin.

A counter sized from the clock frequency raises a status output for the settling time that follows each enable. Two copies of the block, each given its own bus address through a parameter, make up a two-comparator subsystem. The analog comparator, the reference voltage and the interrupt priority logic are outside this block.

Top module: `cmpc_top`

## Requirements
- R1: After reset the register reads 0x00. Bits 7 and 6 always read 0, and writes to them are ignored.
- R2: Register bit 5 is the enable, bit 4 the positive-input select, bit 3 the negative-input select and bit 2 the pin output enable. All four are read/write. The enable, the positive select and the negative select drive `cmp_on`, `pos_sel` and `neg_sel`. On `pos_sel`, 0 picks input A and 1 picks input B. On `neg_sel`, 0 picks the reference pin and 1 picks the internal reference.
- R3: Only bus address `BASE_ADDR` reaches the register (default 0xAC; the second instance uses 0xAD). A write to any other address changes nothing, and a read of any other address returns 0x00.
- R4: Bit 1 holds `raw_cmp` after two clock flops. A change that is stable before one rising edge reads back after the second rising edge. A pulse that starts and ends between two rising edges is not seen. Bit 1 is read-only, so writing it has no effect.
- R5: Bit 0, the flag, sets on every change of bit 1, both rising and falling. It becomes visible one edge after bit 1 changes. Writing 1 to bit 0 leaves the flag as it is.
- R6: Writing 0 to bit 0 clears the flag. If a change of bit 1 is detected in the same cycle as that write, the flag stays set.
- R7: When the enable is 0, bits 1 and 0 read 0. A write that clears the enable clears both bits at that same edge.
- R8: `pin_out` follows `raw_cmp` with no clocked stage only while both the enable and the pin output enable are 1. Otherwise it is low.
- R9: `irq` is the flag ANDed with `irq_en`.
- R10: Each 0-to-1 write of the enable raises `settling` for exactly ceil(`CLK_HZ`·`SETTLE_NS`/1e9) cycles (500 at the defaults). Clearing the enable drops `settling` at once. `settling` does not hold off flag setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on the address |
| raw_cmp | input | 1 | Asynchronous analog comparator decision |
| irq_en | input | 1 | Interrupt enable from the interrupt controller |
| cmp_on | output | 1 | Analog comparator power/enable |
| pos_sel | output | 1 | Positive-input mux select |
| neg_sel | output | 1 | Negative-input mux select |
| pin_out | output | 1 | Gated raw comparator decision to the pin |
| irq | output | 1 | Interrupt request |
| settling | output | 1 | High while the post-enable settle time runs |

## Verification
Two of the block's functions can act in the same cycle: the hardware setting of the flag when the result changes, and a software write that clears it. The same holds for a result change and a write that disables the comparator. The bench raises `raw_cmp` just after a falling edge and counts two falling edges. It then issues the clearing write so that the write's edge is the one where the change is detected. The flag must read 1, where the same write on a quiet cycle reads 0. For the second case, a disabling write lands while the result is 1, and both bits must read 0 straight after that edge.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;

  localparam int FLAG_BIT = 0;
  localparam int OUT_BIT  = 1;
  localparam int OE_BIT   = 2;
  localparam int NEG_BIT  = 3;
  localparam int POS_BIT  = 4;
  localparam int EN_BIT   = 5;

  typedef struct packed {
    logic en;
    logic pos;
    logic neg;
    logic oe;
  } cmpc_cfg_t;

  // Settle cycles = ceil(clk_hz * ns / 1e9)
  function automatic int unsigned settle_cycles(input longint unsigned clk_hz,
                                                input longint unsigned ns);
    longint unsigned prod;
    prod = clk_hz * ns;
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  function automatic cmpc_cfg_t cfg_from_byte(input logic [7:0] b);
    cmpc_cfg_t c;
    c.en  = b[EN_BIT];
    c.pos = b[POS_BIT];
    c.neg = b[NEG_BIT];
    c.oe  = b[OE_BIT];
    return c;
  endfunction

  function automatic logic [7:0] cfg_to_byte(input cmpc_cfg_t c,
                                             input logic out_bit,
                                             input logic flag_bit);
    logic [7:0] b;
    b = 8'h00;
    b[EN_BIT]   = c.en;
    b[POS_BIT]  = c.pos;
    b[NEG_BIT]  = c.neg;
    b[OE_BIT]   = c.oe;
    b[OUT_BIT]  = out_bit;
    b[FLAG_BIT] = flag_bit;
    return b;
  endfunction

endpackage

// File: rtl/cmpc_sync.sv
module cmpc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sh <= '0;
    else if (clr) sh <= '0;
    else          sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/cmpc_flag.sv
module cmpc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en_now,
  input  logic en_next,
  input  logic out_bit,
  input  logic sw_clr,
  output logic change,
  output logic flag
);
  logic prev_q;
  logic flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= out_bit;
  end

  assign change = en_now & (out_bit ^ prev_q);

  // disable beats all; hardware set beats software clear
  always_comb begin
    if (!en_next)    flag_d = 1'b0;
    else if (change) flag_d = 1'b1;
    else if (sw_clr) flag_d = 1'b0;
    else             flag_d = flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end
endmodule

// File: rtl/cmpc_settle.sv
module cmpc_settle #(
  parameter int unsigned CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic settling
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (abort)      cnt <= '0;
    else if (start)      cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign settling = (cnt != '0);
endmodule

// File: rtl/cmpc_top.sv
module cmpc_top #(
  parameter logic [7:0]      BASE_ADDR = 8'hAC,
  parameter int unsigned     CLK_HZ    = 50_000_000,
  parameter int unsigned     SETTLE_NS = 10_000,
  parameter int              SYNC_STG  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       raw_cmp,
  input  logic       irq_en,
  output logic       cmp_on,
  output logic       pos_sel,
  output logic       neg_sel,
  output logic       pin_out,
  output logic       irq,
  output logic       settling
);
  import cmpc_pkg::*;

  localparam int unsigned SETTLE_CYC = settle_cycles(64'(CLK_HZ), 64'(SETTLE_NS));

  cmpc_cfg_t cfg_q, cfg_nxt;
  logic hit, wr_hit;
  logic ce_q, ce_nxt;
  logic sync_q, co_bit;
  logic sw_clr, co_change, flag_q;
  logic settle_start;
  logic unused_wbits;

  assign hit    = (bus_addr == BASE_ADDR);
  assign wr_hit = bus_wr & hit;

  assign cfg_nxt = wr_hit ? cfg_from_byte(bus_wdata) : cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_nxt;
  end

  assign ce_q   = cfg_q.en;
  assign ce_nxt = cfg_nxt.en;

  // reserved bits and the read-only result bit are not stored
  assign unused_wbits = ^{bus_wdata[7:6], bus_wdata[OUT_BIT]};

  cmpc_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!ce_q),
    .d     (raw_cmp),
    .q     (sync_q)
  );

  assign co_bit = sync_q & ce_q;
  assign sw_clr = wr_hit & ~bus_wdata[FLAG_BIT];

  cmpc_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_now  (ce_q),
    .en_next (ce_nxt),
    .out_bit (co_bit),
    .sw_clr  (sw_clr),
    .change  (co_change),
    .flag    (flag_q)
  );

  assign settle_start = ce_nxt & ~ce_q;

  cmpc_settle #(.CYCLES(SETTLE_CYC)) u_settle (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (settle_start),
    .abort    (!ce_nxt),
    .settling (settling)
  );

  assign bus_rdata = hit ? cfg_to_byte(cfg_q, co_bit, flag_q) : 8'h00;
  assign cmp_on    = cfg_q.en;
  assign pos_sel   = cfg_q.pos;
  assign neg_sel   = cfg_q.neg;
  assign pin_out   = raw_cmp & cfg_q.oe & cfg_q.en;
  assign irq       = flag_q & irq_en;
endmodule

// File: rtl/cmpc_checker.sv
module cmpc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       raw_cmp,
  input logic       ce_q,
  input logic       ce_nxt,
  input logic       co_bit,
  input logic       flag_q,
  input logic       change,
  input logic       sw_clr,
  input logic       settling,
  input logic       pin_out,
  input logic       irq,
  input logic [7:0] bus_rdata
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7:6] == 2'b00);

  a_r4_two_flop_path: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_q && $past(ce_q) && $past(ce_q, 2)) |-> (co_bit == $past(raw_cmp, 2)));

  a_r5_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (change && ce_nxt) |=> flag_q);

  a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (change && sw_clr && ce_nxt) |=> flag_q);

  a_r7_off_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_q |-> (!co_bit && !flag_q));

  a_r8_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_q |-> !pin_out);

  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q);

  a_r10_settle_starts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce_q) |-> settling);

  a_r10_settle_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_q |-> !settling);
endmodule

bind cmpc_top cmpc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .raw_cmp   (raw_cmp),
  .ce_q      (ce_q),
  .ce_nxt    (ce_nxt),
  .co_bit    (co_bit),
  .flag_q    (flag_q),
  .change    (co_change),
  .sw_clr    (sw_clr),
  .settling  (settling),
  .pin_out   (pin_out),
  .irq       (irq),
  .bus_rdata (bus_rdata)
);

// File: tb/cmpc_top_tb_top.sv
module cmpc_top_tb_top;
  localparam logic [7:0] BASE = 8'hAC;
  // 50 MHz for 10 us -> 500 cycles
  localparam int EXP_SETTLE = (50 * 10_000) / 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = BASE;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       raw_cmp = 1'b0;
  logic       irq_en = 1'b0;
  logic       cmp_on, pos_sel, neg_sel, pin_out, irq, settling;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  cmpc_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .raw_cmp(raw_cmp),
    .irq_en(irq_en), .cmp_on(cmp_on), .pos_sel(pos_sel), .neg_sel(neg_sel),
    .pin_out(pin_out), .irq(irq), .settling(settling)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = BASE;
    @(negedge clk);
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
    bus_addr = a; #1;
    v = bus_rdata;
    bus_addr = BASE;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd_reg(BASE, v);
    check("R1 reset value", v, 8'h00);
    check("R8 pin low in reset state", pin_out, 0);
    check("R10 not settling in reset state", settling, 0);
  endtask

  task automatic t_fields();
    logic [7:0] v;
    wr_reg(BASE, 8'hFC);
    rd_reg(BASE, v);
    check("R1 reserved ignored, R2 fields stored", v, 8'h3C);
    check("R2 cmp_on", cmp_on, 1);
    check("R2 pos_sel", pos_sel, 1);
    check("R2 neg_sel", neg_sel, 1);
    wr_reg(BASE, 8'h28);
    check("R2 pos_sel back to A", pos_sel, 0);
    check("R2 neg_sel internal ref", neg_sel, 1);
    wr_reg(BASE, 8'h00);
    rd_reg(BASE, v);
    check("R2 cleared", v, 8'h00);
  endtask

  task automatic t_addr();
    logic [7:0] v;
    wr_reg(BASE + 8'd1, 8'h3C);
    rd_reg(BASE, v);
    check("R3 foreign write ignored", v, 8'h00);
    check("R3 foreign write no cmp_on", cmp_on, 0);
    wr_reg(BASE, 8'h3C);
    rd_reg(BASE + 8'd1, v);
    check("R3 foreign read zero", v, 8'h00);
    wr_reg(BASE, 8'h00);
  endtask

  task automatic t_latency_and_flag();
    logic [7:0] v;
    raw_cmp = 1'b0;
    wr_reg(BASE, 8'h20);
    repeat (3) @(negedge clk);
    raw_cmp = 1'b1;
    @(negedge clk);
    rd_reg(BASE, v);
    check("R4 result not yet after one edge", v[1], 0);
    @(negedge clk);
    rd_reg(BASE, v);
    check("R4 result after two edges", v[1], 1);
    check("R5 flag one edge later not yet", v[0], 0);
    @(negedge clk);
    rd_reg(BASE, v);
    check("R5 flag set on rise", v[0], 1);
    check("R10 settling does not block flag", settling, 1);
    irq_en = 1'b1; #1;
    check("R9 irq with enable", irq, 1);
    irq_en = 1'b0; #1;
    check("R9 irq masked", irq, 0);
    wr_reg(BASE, 8'h23);
    rd_reg(BASE, v);
    check("R5 writing 1 keeps flag", v[0], 1);
    check("R4 result bit read-only", v[1], 1);
    wr_reg(BASE, 8'h20);
    rd_reg(BASE, v);
    check("R6 write 0 clears flag", v[0], 0);
    irq_en = 1'b1; #1;
    check("R9 no irq without flag", irq, 0);
    irq_en = 1'b0;
    raw_cmp = 1'b0;
    repeat (2) @(negedge clk);
    rd_reg(BASE, v);
    check("R4 result falls", v[1], 0);
    @(negedge clk);
    rd_reg(BASE, v);
    check("R5 flag set on fall", v[0], 1);
    wr_reg(BASE, 8'h22);
    rd_reg(BASE, v);
    check("R4 writing result bit no effect", v[1], 0);
  endtask

  task automatic t_glitch();
    logic [7:0] v;
    wr_reg(BASE, 8'h20);
    #2 raw_cmp = 1'b1;
    #5 raw_cmp = 1'b0;
    repeat (4) @(negedge clk);
    rd_reg(BASE, v);
    check("R4 short glitch unseen", v[1:0], 2'b00);
  endtask

  task automatic t_set_wins();
    logic [7:0] v;
    wr_reg(BASE, 8'h20);
    raw_cmp = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_reg(BASE, 8'h20);
    rd_reg(BASE, v);
    check("R6 set wins over clear", v[0], 1);
    check("R4 result high", v[1], 1);
  endtask

  task automatic t_disable();
    logic [7:0] v;
    wr_reg(BASE, 8'h04);
    rd_reg(BASE, v);
    check("R7 disable clears result and flag", v, 8'h04);
    check("R8 pin low when disabled", pin_out, 0);
    repeat (3) @(negedge clk);
    rd_reg(BASE, v);
    check("R7 stays clear while disabled", v[1:0], 2'b00);
  endtask

  task automatic t_pin();
    wr_reg(BASE, 8'h24);
    raw_cmp = 1'b0; #3;
    check("R8 pin follows low", pin_out, 0);
    raw_cmp = 1'b1; #1;
    check("R8 pin follows raw unclocked", pin_out, 1);
    raw_cmp = 1'b0; #1;
    check("R8 pin follows fall", pin_out, 0);
    @(negedge clk);
    wr_reg(BASE, 8'h20);
    raw_cmp = 1'b1; #1;
    check("R8 pin low without output enable", pin_out, 0);
    raw_cmp = 1'b0;
    wr_reg(BASE, 8'h00);
  endtask

  task automatic t_settle();
    int n;
    wr_reg(BASE, 8'h00);
    wr_reg(BASE, 8'h20);
    n = 0;
    for (int i = 0; i < EXP_SETTLE + 50; i++) begin
      if (settling) n++;
      @(negedge clk);
    end
    check("R10 settle length", n, EXP_SETTLE);
    wr_reg(BASE, 8'h00);
    wr_reg(BASE, 8'h20);
    repeat (10) @(negedge clk);
    check("R10 settling during restart", settling, 1);
    wr_reg(BASE, 8'h00);
    check("R10 disable drops settling", settling, 0);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_addr();
    t_latency_and_flag();
    t_glitch();
    t_set_wins();
    t_disable();
    t_pin();
    t_settle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule